// File: doc/BRIEF.md
# Exclusive Victim Second-Level Cache

This block is a small set-associative second-level cache placed between a first-level cache and a memory port. It never holds a copy of a line that the first level holds. Lines enter only when the first level evicts them, together with a dirty flag. When the first level misses, it asks this cache for the line. A hit hands the line back with its dirty state and frees the entry here. A miss is forwarded to memory, and the returned line goes straight to the first level without being kept.

To make room for a new victim, the cache takes a free way of the set when one exists. Otherwise it displaces the way selected by a per-set tree pseudo-LRU. A displaced modified line is written back to memory before the new line takes its place. A displaced clean line is dropped without any memory traffic. After reset, a sweep clears every valid bit at one set per cycle, and a busy flag is high while the sweep runs.

Top module: `evx_l2_cache`

## Requirements
- R1: After reset release, `busy` stays high for exactly SETS cycles (64 by default) while the sets are cleared. During that time `fill_ready` and `vic_ready` are low. Every later lookup misses until a victim has been inserted.
- R2: A fill request that hits is answered one cycle after acceptance with `rsp_valid=1` and `rsp_from_l2=1`, carrying the stored data and the dirty flag given at insertion. No memory read is issued.
- R3: A hit invalidates the entry, so a second fill of the same address misses and goes to memory.
- R4: A fill that misses raises `mrd_valid` with the line address, held stable until `mrd_ready`. One cycle after `mrsp_valid`, the response carries the memory data with `rsp_dirty=0` and `rsp_from_l2=0`. Nothing is allocated, so a repeated fill of that address misses again.
- R5: A victim whose set has a free way is accepted (`vic_ready=1`) in the cycle it is presented, with no memory write. Free ways are taken lowest index first.
- R6: When the set is full and the way chosen for replacement is clean, the victim is accepted at once, the displaced line is dropped, and `mwr_valid` stays low.
- R7: When the chosen way is dirty, `mwr_valid` rises one cycle after the victim is presented. It carries that line's address and data, held stable until `mwr_ready`. `vic_ready` stays low until the cycle in which `mwr_ready` is high, and the victim is accepted in that same cycle.
- R8: Replacement uses a 3-bit tree per set over 4 ways. The root selects between the way pairs {0,1} and {2,3}, and one bit per pair selects the way within it. Every insertion points the bits on its path away from the way it wrote. After inserting four lines into empty ways 0,1,2,3 in order, the next insertion displaces the line in way 0, and the one after that displaces the line in way 2.
- R9: When a fill request and a victim are presented in the same cycle, the fill is accepted and `vic_ready` is low. The victim waits until the fill has completed.
- R10: A victim whose address is already present overwrites that entry, with its new data and dirty flag, and displaces nothing. A later fill returns the new contents once and then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busy | output | 1 | High while the valid bits are being cleared |
| fill_valid | input | 1 | First-level line request |
| fill_ready | output | 1 | Request accepted this cycle |
| fill_addr | input | LA_W | Line address requested |
| rsp_valid | output | 1 | One-cycle response pulse to the first level |
| rsp_data | output | LINE_W | Returned line |
| rsp_dirty | output | 1 | Returned line is modified |
| rsp_from_l2 | output | 1 | Response came from this cache, not from memory |
| vic_valid | input | 1 | First-level victim presented, held until accepted |
| vic_ready | output | 1 | Victim accepted this cycle |
| vic_addr | input | LA_W | Victim line address |
| vic_data | input | LINE_W | Victim line data |
| vic_dirty | input | 1 | Victim line is modified |
| mrd_valid | output | 1 | Memory read request |
| mrd_ready | input | 1 | Memory accepts the read request |
| mrd_addr | output | LA_W | Memory read line address |
| mrsp_valid | input | 1 | Memory read data valid |
| mrsp_data | input | LINE_W | Memory read data |
| mwr_valid | output | 1 | Write-back request |
| mwr_ready | input | 1 | Memory accepts the write-back |
| mwr_addr | output | LA_W | Write-back line address |
| mwr_data | output | LINE_W | Write-back line data |

## Verification
Faulty internal state shows up at the ports within one or two cycles. A valid bit left set after a hit turns the next fill of that address into a hit returning stale data, where a memory read is expected. A wrong replacement tree or a wrong free-way choice drops or writes back the wrong line. That error appears on `mwr_addr` in the cycle after the victim is presented, or as a later hit on a line that should be gone. A lost dirty bit shows either as a missing write-back or as `rsp_dirty=0` on the next hit.

// File: rtl/evx_pkg.sv
package evx_pkg;
  typedef enum logic [2:0] {
    ST_INIT,
    ST_IDLE,
    ST_MREQ,
    ST_MWAIT,
    ST_WB
  } evx_state_e;
endpackage

// File: rtl/evx_plru.sv
module evx_plru #(
  parameter int WAYS = 4,
  parameter int SETS = 64,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS),
  localparam int NB    = WAYS - 1
) (
  input  logic             clk,
  input  logic             init_en,
  input  logic [SET_W-1:0] init_set,
  input  logic             touch_en,
  input  logic [SET_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way,
  input  logic [SET_W-1:0] lk_set,
  output logic [WAY_W-1:0] pick_way
);
  logic [NB-1:0] tree_q [SETS];

  // Walk from the root; a bit of 1 sends the search to the upper half.
  function automatic logic [WAY_W-1:0] tree_pick(input logic [NB-1:0] t);
    int node = 0;
    for (int l = 0; l < WAY_W; l++) node = 2 * node + 1 + int'(t[node]);
    return WAY_W'(node - NB);
  endfunction

  // Point every bit on the path of the written way away from it.
  function automatic logic [NB-1:0] tree_touch(input logic [NB-1:0] t,
                                               input logic [WAY_W-1:0] w);
    logic [NB-1:0] r = t;
    int node = 0;
    for (int l = 0; l < WAY_W; l++) begin
      logic d = w[WAY_W-1-l];
      r[node] = ~d;
      node = 2 * node + 1 + int'(d);
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (init_en) tree_q[init_set] <= '0;
    else if (touch_en) tree_q[touch_set] <= tree_touch(tree_q[touch_set], touch_way);
  end

  assign pick_way = tree_pick(tree_q[lk_set]);
endmodule

// File: rtl/evx_tag_store.sv
module evx_tag_store #(
  parameter int WAYS  = 4,
  parameter int SETS  = 64,
  parameter int TAG_W = 20,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_en,
  input  logic [SET_W-1:0] init_set,
  input  logic [SET_W-1:0] lk_set,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic             wr_en,
  input  logic [WAY_W-1:0] wr_way,
  input  logic             wr_dirty,
  input  logic             inv_en,
  input  logic [WAY_W-1:0] inv_way,
  input  logic [WAY_W-1:0] sel_way,
  output logic             hit,
  output logic [WAY_W-1:0] hit_way,
  output logic             free_any,
  output logic [WAY_W-1:0] free_way,
  output logic [WAYS-1:0]  way_dirty,
  output logic [TAG_W-1:0] sel_tag
);
  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAYS-1:0]  dirty_q [SETS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [WAYS-1:0]  hit_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = valid_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
  end

  always_comb begin
    hit_way  = '0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
      if (!valid_q[lk_set][w]) free_way = WAY_W'(w);
    end
  end

  assign hit       = |hit_vec;
  assign free_any  = ~&valid_q[lk_set];
  assign way_dirty = dirty_q[lk_set];
  assign sel_tag   = tag_q[lk_set][sel_way];

  always_ff @(posedge clk) begin
    if (init_en) begin
      valid_q[init_set] <= '0;
    end else begin
      if (inv_en) valid_q[lk_set][inv_way] <= 1'b0;
      if (wr_en) begin
        valid_q[lk_set][wr_way] <= 1'b1;
        dirty_q[lk_set][wr_way] <= wr_dirty;
        tag_q[lk_set][wr_way]   <= lk_tag;
      end
    end
  end

  // R10
  single_copy_chk: assert property (@(posedge clk) disable iff (!rst_n || init_en)
    $onehot0(hit_vec));
endmodule

// File: rtl/evx_data_store.sv
module evx_data_store #(
  parameter int WAYS   = 4,
  parameter int SETS   = 64,
  parameter int LINE_W = 512,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [SET_W-1:0]  set_idx,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [LINE_W-1:0] wr_data,
  input  logic [WAY_W-1:0]  rd_way,
  output logic [LINE_W-1:0] rd_data
);
  logic [LINE_W-1:0] line_q [SETS*WAYS];

  always_ff @(posedge clk) begin
    if (wr_en) line_q[{set_idx, wr_way}] <= wr_data;
  end

  assign rd_data = line_q[{set_idx, rd_way}];
endmodule

// File: rtl/evx_l2_cache.sv
module evx_l2_cache
  import evx_pkg::*;
#(
  parameter int LA_W       = 26,
  parameter int LINE_BYTES = 64,
  parameter int WAYS       = 4,
  parameter int SETS       = 64,
  localparam int LINE_W = 8 * LINE_BYTES,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int SET_W  = $clog2(SETS),
  localparam int TAG_W  = LA_W - SET_W
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              busy,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [LA_W-1:0]   fill_addr,
  output logic              rsp_valid,
  output logic [LINE_W-1:0] rsp_data,
  output logic              rsp_dirty,
  output logic              rsp_from_l2,
  input  logic              vic_valid,
  output logic              vic_ready,
  input  logic [LA_W-1:0]   vic_addr,
  input  logic [LINE_W-1:0] vic_data,
  input  logic              vic_dirty,
  output logic              mrd_valid,
  input  logic              mrd_ready,
  output logic [LA_W-1:0]   mrd_addr,
  input  logic              mrsp_valid,
  input  logic [LINE_W-1:0] mrsp_data,
  output logic              mwr_valid,
  input  logic              mwr_ready,
  output logic [LA_W-1:0]   mwr_addr,
  output logic [LINE_W-1:0] mwr_data
);
  function automatic logic [SET_W-1:0] set_of(input logic [LA_W-1:0] a);
    return a[SET_W-1:0];
  endfunction
  function automatic logic [TAG_W-1:0] tag_of(input logic [LA_W-1:0] a);
    return a[LA_W-1:SET_W];
  endfunction

  evx_state_e        state_q;
  logic [SET_W-1:0]  init_cnt_q;
  logic [LA_W-1:0]   fill_addr_q;
  logic [WAY_W-1:0]  wb_way_q;
  logic              rsp_valid_q, rsp_dirty_q, rsp_src_q;
  logic [LINE_W-1:0] rsp_data_q;

  logic [LA_W-1:0]   lk_addr;
  logic [SET_W-1:0]  lk_set;
  logic              hit, free_any, fill_go, vic_idle, need_wb, wb_go, ins_en, inv_en;
  logic [WAY_W-1:0]  hit_way, free_way, pick_way, vic_target, ins_way, rd_way;
  logic [WAYS-1:0]   way_dirty;
  logic [TAG_W-1:0]  sel_tag;
  logic [LINE_W-1:0] rd_data;

  assign lk_addr    = (state_q == ST_IDLE && fill_valid) ? fill_addr : vic_addr;
  assign lk_set     = set_of(lk_addr);
  assign fill_ready = (state_q == ST_IDLE);
  assign fill_go    = fill_valid && fill_ready;
  assign vic_idle   = (state_q == ST_IDLE) && !fill_valid && vic_valid;
  assign vic_target = hit ? hit_way : (free_any ? free_way : pick_way);
  assign need_wb    = !hit && !free_any && way_dirty[pick_way];
  assign wb_go      = (state_q == ST_WB) && mwr_ready;
  assign vic_ready  = (vic_idle && !need_wb) || wb_go;
  assign ins_en     = vic_valid && vic_ready;
  assign ins_way    = (state_q == ST_WB) ? wb_way_q : vic_target;
  assign inv_en     = fill_go && hit;
  assign rd_way     = (state_q == ST_WB) ? wb_way_q : hit_way;

  assign busy      = (state_q == ST_INIT);
  assign mrd_valid = (state_q == ST_MREQ);
  assign mrd_addr  = fill_addr_q;
  assign mwr_valid = (state_q == ST_WB);
  assign mwr_addr  = {sel_tag, lk_set};
  assign mwr_data  = rd_data;

  assign rsp_valid   = rsp_valid_q;
  assign rsp_data    = rsp_data_q;
  assign rsp_dirty   = rsp_dirty_q;
  assign rsp_from_l2 = rsp_src_q;

  evx_tag_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .init_en(busy), .init_set(init_cnt_q),
    .lk_set(lk_set), .lk_tag(tag_of(lk_addr)),
    .wr_en(ins_en), .wr_way(ins_way), .wr_dirty(vic_dirty),
    .inv_en(inv_en), .inv_way(hit_way), .sel_way(wb_way_q),
    .hit(hit), .hit_way(hit_way), .free_any(free_any), .free_way(free_way),
    .way_dirty(way_dirty), .sel_tag(sel_tag)
  );

  evx_plru #(.WAYS(WAYS), .SETS(SETS)) u_plru (
    .clk(clk), .init_en(busy), .init_set(init_cnt_q),
    .touch_en(ins_en), .touch_set(lk_set), .touch_way(ins_way),
    .lk_set(lk_set), .pick_way(pick_way)
  );

  evx_data_store #(.WAYS(WAYS), .SETS(SETS), .LINE_W(LINE_W)) u_data (
    .clk(clk), .wr_en(ins_en), .set_idx(lk_set), .wr_way(ins_way),
    .wr_data(vic_data), .rd_way(rd_way), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_INIT;
      init_cnt_q  <= '0;
      fill_addr_q <= '0;
      wb_way_q    <= '0;
      rsp_valid_q <= 1'b0;
      rsp_dirty_q <= 1'b0;
      rsp_src_q   <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (state_q)
        ST_INIT: begin
          init_cnt_q <= init_cnt_q + 1'b1;
          if (init_cnt_q == SET_W'(SETS - 1)) state_q <= ST_IDLE;
        end
        ST_IDLE: begin
          if (fill_go) begin
            if (hit) begin
              rsp_valid_q <= 1'b1;
              rsp_data_q  <= rd_data;
              rsp_dirty_q <= way_dirty[hit_way];
              rsp_src_q   <= 1'b1;
            end else begin
              fill_addr_q <= fill_addr;
              state_q     <= ST_MREQ;
            end
          end else if (vic_idle && need_wb) begin
            wb_way_q <= pick_way;
            state_q  <= ST_WB;
          end
        end
        ST_MREQ:  if (mrd_ready) state_q <= ST_MWAIT;
        ST_MWAIT: if (mrsp_valid) begin
          rsp_valid_q <= 1'b1;
          rsp_data_q  <= mrsp_data;
          rsp_dirty_q <= 1'b0;
          rsp_src_q   <= 1'b0;
          state_q     <= ST_IDLE;
        end
        ST_WB:    if (mwr_ready) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  // R1
  busy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!fill_ready && !vic_ready));
  // R2
  hit_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_go && hit) |=> (rsp_valid && rsp_from_l2 && !mrd_valid));
  // R4
  mrd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mrd_valid && !mrd_ready) |=> (mrd_valid && $stable(mrd_addr)));
  // R4
  mem_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MWAIT && mrsp_valid) |=> (rsp_valid && !rsp_dirty && !rsp_from_l2));
  // R7
  mwr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mwr_valid && !mwr_ready) |=> (mwr_valid && $stable(mwr_addr)));
  // R7
  wb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mwr_valid && vic_ready) |-> mwr_ready);
  // R9
  fill_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_go |-> !vic_ready);
endmodule

// File: tb/evx_l2_cache_tb.sv
module evx_l2_cache_tb;
  localparam int CLK_NS = 10;
  localparam int LA_W = 26;
  localparam int LW   = 512;
  localparam int SETS = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic busy, fill_valid, fill_ready, rsp_valid, rsp_dirty, rsp_from_l2;
  logic vic_valid, vic_ready, vic_dirty, mrd_valid, mrd_ready, mrsp_valid;
  logic mwr_valid, mwr_ready;
  logic [LA_W-1:0] fill_addr, vic_addr, mrd_addr, mwr_addr;
  logic [LW-1:0]   rsp_data, vic_data, mrsp_data, mwr_data;
  int vectors = 0;
  int miscompares = 0;

  always #(CLK_NS/2) clk = ~clk;

  evx_l2_cache u_dut (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_addr(fill_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_dirty(rsp_dirty), .rsp_from_l2(rsp_from_l2),
    .vic_valid(vic_valid), .vic_ready(vic_ready), .vic_addr(vic_addr),
    .vic_data(vic_data), .vic_dirty(vic_dirty),
    .mrd_valid(mrd_valid), .mrd_ready(mrd_ready), .mrd_addr(mrd_addr),
    .mrsp_valid(mrsp_valid), .mrsp_data(mrsp_data),
    .mwr_valid(mwr_valid), .mwr_ready(mwr_ready), .mwr_addr(mwr_addr), .mwr_data(mwr_data)
  );

  function automatic logic [LA_W-1:0] mk(input int s, input int t);
    return {20'(t), 6'(s)};
  endfunction
  function automatic logic [LW-1:0] vdat(input logic [LA_W-1:0] a, input logic [31:0] salt);
    return {16{{6'b0, a} ^ salt}};
  endfunction
  function automatic logic [LW-1:0] mdat(input logic [LA_W-1:0] a);
    return {16{32'hC0DE_0000 ^ {6'b0, a}}};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  // Serve a memory read that is already requested at the current negedge.
  task automatic serve_miss(input logic [LA_W-1:0] a, input string req);
    chk(mrd_valid && mrd_addr == a, req, LW'(mrd_addr), LW'(a));
    mrd_ready = 1'b1;
    @(posedge clk); #1 mrd_ready = 1'b0;
    repeat (2) @(negedge clk);
    chk(!rsp_valid, req, LW'(rsp_valid), '0);
    mrsp_valid = 1'b1;
    mrsp_data  = mdat(a);
    @(posedge clk); #1 mrsp_valid = 1'b0;
    @(negedge clk);
    chk(rsp_valid && !rsp_from_l2 && !rsp_dirty, req, LW'({rsp_valid, rsp_from_l2, rsp_dirty}), LW'(3'b100));
    chk(rsp_data == mdat(a), req, rsp_data, mdat(a));
  endtask

  task automatic fill(input logic [LA_W-1:0] a, input bit exp_hit, input logic [LW-1:0] exp_d,
                      input bit exp_dty, input string req);
    @(negedge clk);
    fill_valid = 1'b1;
    fill_addr  = a;
    #1 chk(fill_ready, req, LW'(fill_ready), 1);
    @(posedge clk); #1 fill_valid = 1'b0;
    @(negedge clk);
    chk(rsp_valid == exp_hit, {req, " hit/miss"}, LW'(rsp_valid), LW'(exp_hit));
    if (rsp_valid) begin
      chk(rsp_from_l2 && !mrd_valid, req, LW'({rsp_from_l2, mrd_valid}), LW'(2'b10));
      chk(rsp_data == exp_d, req, rsp_data, exp_d);
      chk(rsp_dirty == exp_dty, req, LW'(rsp_dirty), LW'(exp_dty));
    end else begin
      serve_miss(a, req);
    end
  endtask

  task automatic ins(input logic [LA_W-1:0] a, input logic [LW-1:0] d, input bit dty,
                     input bit exp_wb, input logic [LA_W-1:0] wa, input logic [LW-1:0] wd,
                     input string req);
    int stalls = 0;
    bit seen = 0, done = 0;
    logic [LA_W-1:0] ga = '0;
    logic [LW-1:0] gd = '0;
    @(negedge clk);
    vic_valid = 1'b1; vic_addr = a; vic_data = d; vic_dirty = dty; mwr_ready = 1'b0;
    for (int i = 0; i < 20 && !done; i++) begin
      #1;
      if (mwr_valid) begin
        seen = 1; ga = mwr_addr; gd = mwr_data;
        if (stalls < 2) begin
          stalls++;
          chk(!vic_ready, {req, " wait for write-back"}, LW'(vic_ready), '0);
        end else begin
          mwr_ready = 1'b1;
          #1;
        end
      end
      if (vic_ready) done = 1;
      else @(negedge clk);
    end
    chk(done, {req, " accepted"}, LW'(done), 1);
    chk(seen == exp_wb, {req, " write-back"}, LW'(seen), LW'(exp_wb));
    if (exp_wb) begin
      chk(ga == wa, {req, " wb addr"}, LW'(ga), LW'(wa));
      chk(gd == wd, {req, " wb data"}, gd, wd);
    end
    @(posedge clk); #1;
    vic_valid = 1'b0; mwr_ready = 1'b0;
  endtask

  task automatic t_reset();
    int n = 0;
    @(negedge clk);
    rst_n = 1'b1;
    #1 chk(busy && !fill_ready, "R1 busy at release", LW'({busy, fill_ready}), LW'(2'b10));
    chk(!rsp_valid && !mrd_valid && !mwr_valid, "R1 outputs idle", LW'({rsp_valid, mrd_valid, mwr_valid}), '0);
    while (busy && n < 1000) begin @(negedge clk); n++; end
    chk(n == SETS, "R1 busy length", LW'(n), LW'(SETS));
    fill(mk(5, 7), 0, '0, 0, "R1 empty after init");
  endtask

  task automatic t_hit_inv();
    logic [LA_W-1:0] a = mk(3, 100), b = mk(3, 200);
    ins(a, vdat(a, 32'h11), 1, 0, '0, '0, "R5 insert free way");
    fill(a, 1, vdat(a, 32'h11), 1, "R2 hit returns line and dirty");
    fill(a, 0, '0, 0, "R3 invalidated after hit");
    fill(b, 0, '0, 0, "R4 miss from memory");
    fill(b, 0, '0, 0, "R4 no allocation on miss");
  endtask

  task automatic t_clean_plru();
    logic [LA_W-1:0] t[6];
    for (int i = 0; i < 6; i++) t[i] = mk(10, 300 + i);
    for (int i = 0; i < 4; i++) ins(t[i], vdat(t[i], 32'h22), 0, 0, '0, '0, "R5 fill set");
    ins(t[4], vdat(t[4], 32'h22), 0, 0, '0, '0, "R6 clean displaced no write");
    ins(t[5], vdat(t[5], 32'h33), 1, 0, '0, '0, "R6 second clean displacement");
    fill(t[0], 0, '0, 0, "R8 way 0 displaced first");
    fill(t[2], 0, '0, 0, "R8 way 2 displaced second");
    fill(t[1], 1, vdat(t[1], 32'h22), 0, "R8 way 1 kept");
    fill(t[3], 1, vdat(t[3], 32'h22), 0, "R8 way 3 kept");
    fill(t[5], 1, vdat(t[5], 32'h33), 1, "R8 newest kept");
  endtask

  task automatic t_dirty_wb();
    logic [LA_W-1:0] u[6];
    for (int i = 0; i < 6; i++) u[i] = mk(20, 500 + i);
    for (int i = 0; i < 4; i++) ins(u[i], vdat(u[i], 32'h44), 1, 0, '0, '0, "R5 dirty fill");
    ins(u[4], vdat(u[4], 32'h44), 1, 1, u[0], vdat(u[0], 32'h44), "R7 write-back way 0");
    ins(u[5], vdat(u[5], 32'h44), 1, 1, u[2], vdat(u[2], 32'h44), "R8 write-back way 2");
    fill(u[4], 1, vdat(u[4], 32'h44), 1, "R7 inserted after write-back");
  endtask

  task automatic t_same_cycle();
    logic [LA_W-1:0] v = mk(30, 700), w = mk(30, 701);
    @(negedge clk);
    fill_valid = 1'b1; fill_addr = w;
    vic_valid = 1'b1; vic_addr = v; vic_data = vdat(v, 32'h55); vic_dirty = 1'b0;
    #1 chk(fill_ready && !vic_ready, "R9 fill wins", LW'({fill_ready, vic_ready}), LW'(2'b10));
    @(posedge clk); #1 fill_valid = 1'b0;
    @(negedge clk);
    chk(!vic_ready, "R9 victim waits during miss", LW'(vic_ready), '0);
    serve_miss(w, "R9 fill completes first");
    #1 chk(vic_ready, "R9 victim taken after fill", LW'(vic_ready), 1);
    @(posedge clk); #1 vic_valid = 1'b0;
    fill(v, 1, vdat(v, 32'h55), 0, "R9 victim stored");
  endtask

  task automatic t_dup();
    logic [LA_W-1:0] x = mk(40, 900);
    ins(x, vdat(x, 32'h66), 1, 0, '0, '0, "R10 first copy");
    ins(x, vdat(x, 32'h77), 0, 0, '0, '0, "R10 overwrite no write-back");
    fill(x, 1, vdat(x, 32'h77), 0, "R10 newest contents");
    fill(x, 0, '0, 0, "R10 single entry");
  endtask

  initial begin
    fill_valid = 0; fill_addr = '0; vic_valid = 0; vic_addr = '0; vic_data = '0; vic_dirty = 0;
    mrd_ready = 0; mrsp_valid = 0; mrsp_data = '0; mwr_ready = 0;
    repeat (3) @(posedge clk);
    t_reset();
    t_hit_inv();
    t_clean_plru();
    t_dirty_wb();
    t_same_cycle();
    t_dup();
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end
endmodule